// File: doc/BRIEF.md
# Integer Add-Subtract Unit with Carry

This block computes the arithmetic result for five integer operations on two 32-bit operands: plain add, add including an incoming carry, plain subtract, subtract that takes one extra away when the carry is clear, and reverse subtract (second operand minus first). Add and plain subtract may take a 12-bit zero-extended immediate in place of the second operand. Every subtraction is formed as the first adder input plus the inverted second input plus a carry-in. As a result, the carry out reads 1 when no borrow occurred.

The result and an illegal-combination indication are combinational. The four condition flags (negative, zero, carry, overflow) sit in a small register. That register loads only when the update enable is high and the operation is legal. Chaining add-with-carry or subtract-with-carry across words is done outside the block, by feeding the stored carry back into the carry input.

Top module: `addsub_unit`

## Requirements
- R1: Operation code 0 (add) gives `opnd_a` plus `opnd_b`, or plus the zero-extended `imm_val` when `imm_sel` is 1, modulo 2^32.
- R2: Operation code 1 (add with carry) gives `opnd_a + opnd_b + carry_in`, modulo 2^32.
- R3: Operation code 2 (subtract) gives `opnd_a` minus `opnd_b`, or minus the zero-extended `imm_val` when `imm_sel` is 1, modulo 2^32.
- R4: Operation code 3 (subtract with carry) gives `opnd_a - opnd_b - 1 + carry_in`, modulo 2^32.
- R5: Operation code 4 (reverse subtract) gives `opnd_b - opnd_a`, modulo 2^32.
- R6: Codes 5 to 7, or `imm_sel` = 1 with any code other than 0 or 2, raise `illegal` in the same cycle and force `result` to zero. The stored flags are then not written, even if `flag_we` is 1.
- R7: The stored flags load only on a rising clock edge where `flag_we` is 1 and the operation is legal. Otherwise they hold. New values appear after that edge.
- R8: The stored N equals bit 31 of the result. The stored Z is 1 exactly when all 32 result bits are zero.
- R9: The stored C is the unsigned carry out for additions. For subtractions it is 1 when no borrow occurs, meaning the unsigned minuend is at least the subtrahend plus any borrow.
- R10: The stored V is 1 when the true signed result lies outside the 32-bit two's-complement range. The boundary cases are 0x7FFFFFFF + 1 and 0x80000000 - 1.
- R11: Reset is synchronous and active low, and clears all four stored flags to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 3 | Operation code (0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 reverse subtract) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| imm_sel | input | 1 | Use the immediate instead of `opnd_b` |
| imm_val | input | 12 | Unsigned immediate |
| carry_in | input | 1 | Incoming carry flag |
| flag_we | input | 1 | Flag update enable |
| result | output | 32 | Arithmetic result |
| illegal | output | 1 | Illegal operation or immediate combination |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry flag |
| flag_v | output | 1 | Stored overflow flag |

## Verification
`result` and `illegal` have no register on their path. They are due in the same cycle the operands are applied, so the driver checks them one time unit after it drives inputs on the falling edge. The flags are due one rising edge later. For each operation the driver queues the expected flag set, which is the previous set when no update is allowed. The monitor pops and compares that entry shortly after the next rising edge. Multiword chains read the stored carry back from the ports before the next word is applied, and then compare the joined 64-bit result with a 64-bit reference.

// File: rtl/addsub_pkg.sv
// Shared types for the add-subtract unit.
// Assumes op codes above OP_RSB are reserved and treated as illegal.
package addsub_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBC = 3'd3,
        OP_RSB = 3'd4
    } op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/addsub_operand_mux.sv
// Operand steering: picks the adder inputs, the inversion and the carry-in
// for each operation, and detects illegal operation/immediate combinations.
// Assumes IMM_W <= DATA_W. On illegal input all adder inputs are driven to zero.
module addsub_operand_mux
    import addsub_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 12
) (
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              imm_sel,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic              carry_in,
    output logic [DATA_W-1:0] add_x,
    output logic [DATA_W-1:0] add_y,
    output logic              add_cin,
    output logic              illegal
);

    localparam int PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] b_eff;

    // Zero-extend the immediate and choose the effective second operand.
    always_comb begin
        imm_ext = {{PAD_W{1'b0}}, imm_val};
        b_eff   = imm_sel ? imm_ext : opnd_b;
    end

    // Map each operation onto x + y + cin, flagging illegal combinations.
    always_comb begin
        add_x   = '0;
        add_y   = '0;
        add_cin = 1'b0;
        illegal = 1'b0;
        case (op_e'(op_sel))
            OP_ADD: begin
                add_x   = opnd_a;
                add_y   = b_eff;
                add_cin = 1'b0;
            end
            OP_ADC: begin
                illegal = imm_sel;
                add_x   = opnd_a;
                add_y   = opnd_b;
                add_cin = carry_in;
            end
            OP_SUB: begin
                add_x   = opnd_a;
                add_y   = ~b_eff;
                add_cin = 1'b1;
            end
            OP_SBC: begin
                illegal = imm_sel;
                add_x   = opnd_a;
                add_y   = ~opnd_b;
                add_cin = carry_in;
            end
            OP_RSB: begin
                illegal = imm_sel;
                add_x   = opnd_b;
                add_y   = ~opnd_a;
                add_cin = 1'b1;
            end
            default: illegal = 1'b1;
        endcase
        if (illegal) begin
            add_x   = '0;
            add_y   = '0;
            add_cin = 1'b0;
        end
    end

endmodule

// File: rtl/addsub_adder.sv
// Core adder with flag generation: sum = x + y + cin.
// N is the top result bit, Z is all-zero detect, C is the carry out,
// V is set when x and y share a sign that the sum does not.
// Assumes subtraction operands arrive already inverted.
module addsub_adder
    import addsub_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] add_x,
    input  logic [DATA_W-1:0] add_y,
    input  logic              add_cin,
    output logic [DATA_W-1:0] sum,
    output flags_t            flags
);

    localparam int EXT_W = DATA_W + 1;
    localparam int MSB   = DATA_W - 1;

    logic [EXT_W-1:0] wide_sum;

    // Full-width add with one extra bit to capture the carry out.
    always_comb begin
        wide_sum = {1'b0, add_x} + {1'b0, add_y} + {{DATA_W{1'b0}}, add_cin};
        sum      = wide_sum[DATA_W-1:0];
    end

    // Derive the four condition flags from the sum and the adder inputs.
    always_comb begin
        flags.n = wide_sum[MSB];
        flags.z = ~|wide_sum[DATA_W-1:0];
        flags.c = wide_sum[DATA_W];
        flags.v = (add_x[MSB] == add_y[MSB]) && (wide_sum[MSB] != add_x[MSB]);
    end

endmodule

// File: rtl/addsub_flag_reg.sv
// Condition flag register: loads new flags when enabled, otherwise holds.
// Assumes a synchronous active-low reset that clears all flags.
module addsub_flag_reg
    import addsub_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  flags_t flags_d,
    output flags_t flags_q
);

    // Hold or update the stored flags on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (load) begin
            flags_q <= flags_d;
        end
    end

endmodule

// File: rtl/addsub_unit.sv
// Top of the add-subtract unit. Result and illegal are combinational.
// The flags are registered and load only on a legal operation with the
// update enable high. Assumes operands are stable around the clock edge.
module addsub_unit
    import addsub_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              imm_sel,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic              carry_in,
    input  logic              flag_we,
    output logic [DATA_W-1:0] result,
    output logic              illegal,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v
);

    logic [DATA_W-1:0] add_x;
    logic [DATA_W-1:0] add_y;
    logic              add_cin;
    logic              bad_op;
    flags_t            next_flags;
    flags_t            held_flags;
    logic              flag_load;

    addsub_operand_mux #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) u_mux (
        .op_sel   (op_sel),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .imm_sel  (imm_sel),
        .imm_val  (imm_val),
        .carry_in (carry_in),
        .add_x    (add_x),
        .add_y    (add_y),
        .add_cin  (add_cin),
        .illegal  (bad_op)
    );

    addsub_adder #(
        .DATA_W (DATA_W)
    ) u_adder (
        .add_x   (add_x),
        .add_y   (add_y),
        .add_cin (add_cin),
        .sum     (result),
        .flags   (next_flags)
    );

    // Flags load only for a legal operation with the update enable high.
    always_comb flag_load = flag_we && !bad_op;

    addsub_flag_reg u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (flag_load),
        .flags_d (next_flags),
        .flags_q (held_flags)
    );

    // Drive the flat output ports.
    always_comb begin
        illegal = bad_op;
        flag_n  = held_flags.n;
        flag_z  = held_flags.z;
        flag_c  = held_flags.c;
        flag_v  = held_flags.v;
    end

endmodule

// File: rtl/addsub_unit_chk.sv
// Property checker for addsub_unit, attached through bind.
module addsub_unit_chk #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_sel,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic              imm_sel,
    input logic [IMM_W-1:0]  imm_val,
    input logic              carry_in,
    input logic              flag_we,
    input logic [DATA_W-1:0] result,
    input logic              illegal,
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_c,
    input logic              flag_v
);

    localparam int PAD_W = DATA_W - IMM_W;

    p_add_imm_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd0 && imm_sel) |-> result == opnd_a + {{PAD_W{1'b0}}, imm_val});

    p_adc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd1 && !imm_sel) |-> result == opnd_a + opnd_b + {{(DATA_W-1){1'b0}}, carry_in});

    p_rsb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd4 && !imm_sel) |-> result == opnd_b - opnd_a);

    p_illegal_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> result == '0);

    p_hold_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_we || illegal) |=> $stable({flag_n, flag_z, flag_c, flag_v}));

    p_n_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && !illegal) |=> flag_n == $past(result[DATA_W-1]));

    p_z_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && !illegal) |=> flag_z == ($past(result) == '0));

    p_reset_clear_r11: assert property (@(posedge clk)
        !rst_n |=> {flag_n, flag_z, flag_c, flag_v} == 4'b0000);

endmodule

bind addsub_unit addsub_unit_chk #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_sel   (op_sel),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .imm_sel  (imm_sel),
    .imm_val  (imm_val),
    .carry_in (carry_in),
    .flag_we  (flag_we),
    .result   (result),
    .illegal  (illegal),
    .flag_n   (flag_n),
    .flag_z   (flag_z),
    .flag_c   (flag_c),
    .flag_v   (flag_v)
);

// File: tb/test_addsub_unit.sv
module test_addsub_unit;

    typedef struct {
        logic [3:0] nzcv;
        string      tag;
    } exp_t;

    logic        clk;
    logic        rst_n;
    logic [2:0]  op_sel;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic        imm_sel;
    logic [11:0] imm_val;
    logic        carry_in;
    logic        flag_we;
    logic [31:0] result;
    logic        illegal;
    logic        flag_n;
    logic        flag_z;
    logic        flag_c;
    logic        flag_v;

    int          checks;
    int          failures;
    bit          done;
    exp_t        sb_q[$];
    logic [3:0]  model_flags;
    logic [31:0] last_res;

    addsub_unit i_addsub_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_sel   (op_sel),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .imm_sel  (imm_sel),
        .imm_val  (imm_val),
        .carry_in (carry_in),
        .flag_we  (flag_we),
        .result   (result),
        .illegal  (illegal),
        .flag_n   (flag_n),
        .flag_z   (flag_z),
        .flag_c   (flag_c),
        .flag_v   (flag_v)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Reference model built from the requirements with 64-bit arithmetic.
    task automatic model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic isel, input logic [11:0] imm, input logic ci,
                         output logic [31:0] res, output logic [3:0] nzcv, output logic ill);
        logic [63:0] ua, ub, full;
        longint      sa, sb, s;
        logic        c;
        logic        brw;
        ua  = {32'b0, a};
        ub  = isel ? {52'b0, imm} : {32'b0, b};
        sa  = longint'(int'(a));
        sb  = isel ? longint'(ub) : longint'(int'(b));
        brw = !ci;
        ill = (op > 3'd4) || (isel && op != 3'd0 && op != 3'd2);
        c = 1'b0;
        s = 0;
        full = 64'b0;
        case (op)
            3'd0: begin full = ua + ub; c = full[32]; s = sa + sb; end
            3'd1: begin full = ua + ub + {63'b0, ci}; c = full[32]; s = sa + sb + longint'(ci); end
            3'd2: begin full = ua - ub; c = (ua >= ub); s = sa - sb; end
            3'd3: begin full = ua - ub - {63'b0, brw}; c = (ua >= ub + {63'b0, brw}); s = sa - sb - longint'(brw); end
            3'd4: begin full = ub - ua; c = (ub >= ua); s = sb - sa; end
            default: ;
        endcase
        if (ill) begin
            res  = 32'b0;
            nzcv = 4'b0;
        end else begin
            res  = full[31:0];
            nzcv = {res[31], (res == 32'b0), c, (s > 64'sd2147483647) || (s < -64'sd2147483648)};
        end
    endtask

    // Driver: applies one operation, checks the combinational outputs,
    // and queues the flag set expected after the next rising edge.
    task automatic run_op(input string tag, input logic [2:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic isel, input logic [11:0] imm,
                          input logic ci, input bit use_flag_c, input logic we);
        logic [31:0] r;
        logic [3:0]  f;
        logic        ill;
        exp_t        e;
        @(negedge clk);
        op_sel   = op;
        opnd_a   = a;
        opnd_b   = b;
        imm_sel  = isel;
        imm_val  = imm;
        carry_in = use_flag_c ? flag_c : ci;
        flag_we  = we;
        #1;
        model(op, a, b, isel, imm, carry_in, r, f, ill);
        check({tag, " result"}, {32'b0, result}, {32'b0, r});
        check({tag, " illegal"}, {63'b0, illegal}, {63'b0, ill});
        last_res = result;
        if (we && !ill) model_flags = f;
        e.nzcv = model_flags;
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compares the stored flags shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " flags"}, {60'b0, flag_n, flag_z, flag_c, flag_v}, {60'b0, e.nzcv});
            end
        end
    end

    task automatic chain_add(input logic [63:0] x, input logic [63:0] y);
        logic [31:0] lo;
        run_op("R2 chain lo", 3'd0, x[31:0], y[31:0], 1'b0, 12'd0, 1'b0, 1'b0, 1'b1);
        lo = last_res;
        run_op("R2 chain hi", 3'd1, x[63:32], y[63:32], 1'b0, 12'd0, 1'b0, 1'b1, 1'b1);
        check("R2 64-bit sum", {last_res, lo}, x + y);
    endtask

    task automatic chain_sub(input logic [63:0] x, input logic [63:0] y);
        logic [31:0] lo;
        run_op("R4 chain lo", 3'd2, x[31:0], y[31:0], 1'b0, 12'd0, 1'b0, 1'b0, 1'b1);
        lo = last_res;
        run_op("R4 chain hi", 3'd3, x[63:32], y[63:32], 1'b0, 12'd0, 1'b0, 1'b1, 1'b1);
        check("R4 64-bit difference", {last_res, lo}, x - y);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        checks = 0; failures = 0; done = 1'b0; model_flags = 4'b0;
        rst_n = 1'b0; op_sel = 3'd0; opnd_a = 32'hFFFF_FFFF; opnd_b = 32'hFFFF_FFFF;
        imm_sel = 1'b0; imm_val = 12'd0; carry_in = 1'b0; flag_we = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 reset flags", {60'b0, flag_n, flag_z, flag_c, flag_v}, 64'b0);
        rst_n = 1'b1;

        // R1 add with register and immediate
        run_op("R1 add", 3'd0, 32'd3, 32'd4, 1'b0, 12'd0, 1'b0, 1'b0, 1'b1);
        run_op("R1 add imm wrap R9", 3'd0, 32'hFFFF_F001, 32'h1234, 1'b1, 12'hFFF, 1'b0, 1'b0, 1'b1);
        // R10 overflow boundaries
        run_op("R10 add 7FFFFFFF+1", 3'd0, 32'h7FFF_FFFF, 32'd1, 1'b0, 12'd0, 1'b0, 1'b0, 1'b1);
        run_op("R10 add 80000000+80000000", 3'd0, 32'h8000_0000, 32'h8000_0000, 1'b0, 12'd0, 1'b0, 1'b0, 1'b1);
        run_op("R10 sub 80000000-1", 3'd2, 32'h8000_0000, 32'd1, 1'b0, 12'd0, 1'b0, 1'b0, 1'b1);
        run_op("R10 sub 7FFFFFFF-FFFFFFFF", 3'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 12'd0, 1'b0, 1'b0, 1'b1);
        // R2 add with carry
        run_op("R2 adc ci=1", 3'd1, 32'd10, 32'd20, 1'b0, 12'd0, 1'b1, 1'b0, 1'b1);
        run_op("R2 adc ci=0", 3'd1, 32'hFFFF_FFFF, 32'd0, 1'b0, 12'd0, 1'b0, 1'b0, 1'b1);
        // R3 subtract, borrow and immediate
        run_op("R3 sub borrow R9", 3'd2, 32'd5, 32'd7, 1'b0, 12'd0, 1'b0, 1'b0, 1'b1);
        run_op("R3 sub imm", 3'd2, 32'd5000, 32'd0, 1'b1, 12'd4095, 1'b0, 1'b0, 1'b1);
        run_op("R3 sub equal R8", 3'd2, 32'h1234_5678, 32'h1234_5678, 1'b0, 12'd0, 1'b0, 1'b0, 1'b1);
        // R4 subtract with carry
        run_op("R4 sbc ci=0", 3'd3, 32'd9, 32'd4, 1'b0, 12'd0, 1'b0, 1'b0, 1'b1);
        run_op("R4 sbc ci=1", 3'd3, 32'd9, 32'd4, 1'b0, 12'd0, 1'b1, 1'b0, 1'b1);
        run_op("R4 sbc 0-0 ci=0", 3'd3, 32'd0, 32'd0, 1'b0, 12'd0, 1'b0, 1'b0, 1'b1);
        // R5 reverse subtract with operands swapped
        run_op("R5 rsb a=10 b=3", 3'd4, 32'd10, 32'd3, 1'b0, 12'd0, 1'b0, 1'b0, 1'b1);
        run_op("R5 rsb a=3 b=10", 3'd4, 32'd3, 32'd10, 1'b0, 12'd0, 1'b0, 1'b0, 1'b1);
        run_op("R5 R10 rsb 0-80000000", 3'd4, 32'h8000_0000, 32'd0, 1'b0, 12'd0, 1'b0, 1'b0, 1'b1);
        // R7 hold when update disabled
        run_op("R7 add no update", 3'd0, 32'd0, 32'd0, 1'b0, 12'd0, 1'b0, 1'b0, 1'b0);
        run_op("R7 sub no update", 3'd2, 32'd1, 32'd2, 1'b0, 12'd0, 1'b0, 1'b0, 1'b0);
        // R6 illegal combinations keep flags
        run_op("R6 adc with imm", 3'd1, 32'd1, 32'd1, 1'b1, 12'd5, 1'b1, 1'b0, 1'b1);
        run_op("R6 rsb with imm", 3'd4, 32'd1, 32'd9, 1'b1, 12'd5, 1'b0, 1'b0, 1'b1);
        run_op("R6 code 6", 3'd6, 32'd7, 32'd8, 1'b0, 12'd0, 1'b0, 1'b0, 1'b1);
        run_op("R6 code 5", 3'd5, 32'd7, 32'd8, 1'b0, 12'd0, 1'b0, 1'b0, 1'b1);
        // Multiword chains against 64-bit reference
        chain_add(64'h0000_0001_FFFF_FFFF, 64'h0000_0002_0000_0001);
        chain_add(64'h7FFF_FFFF_8000_0000, 64'h0000_0000_8000_0000);
        chain_add(64'h1234_5678_0000_0010, 64'h0000_0001_0000_0020);
        chain_sub(64'h0000_0005_0000_0000, 64'h0000_0001_0000_0001);
        chain_sub(64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001);
        chain_sub(64'h0000_0003_0000_0009, 64'h0000_0001_0000_0002);

        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule